// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block runs single-byte read and write transfers from an on-chip host to an external parallel device, such as a character display controller, an external memory or another controller. The host raises a request with a command bit, a byte of write data and, optionally, a fresh address. The block sequences the device pins through an optional address-latch stage, a setup phase, a strobe phase and a hold phase. It then returns read data together with a one-cycle done flag.

A set of configuration inputs is sampled when a request is accepted. These inputs select how the address reaches the device: on dedicated lines, with its low byte sent over the data lines, or with both bytes sent over the data lines. They also select one of two strobe styles, the active level of each control pin, the length of each phase and how the address steps after each transfer. The address is held inside the block, so a run of transfers to consecutive locations needs only one address load.

Top module: `pbm_master`

## Requirements
- R1: After reset, busy, done and pad_doe are 0, pad_addr is 0, and pad_cs, pad_rd, pad_wr, pad_latch_lo and pad_latch_hi are all 1. These are the inactive levels for the reset configuration, which uses active-low pins with chip select enabled.
- R2: A request is taken when req_valid is 1 and busy is 0. busy is 1 from the next cycle until the last hold cycle. done is a single-cycle pulse in the cycle after that, with busy at 0. A request made while busy is ignored: it starts no transfer and changes no address.
- R3: With wait fields S, T and H (0 to 15 each), the setup phase lasts S+1 clocks, the strobe phase T+1 clocks and the hold phase H+1 clocks. One latch clock comes before them in partial mode and two in full mode, so a transfer is busy for S+T+H+3 clocks plus the latch clocks.
- R4: Full mode (cfg_mux=2): in the first busy clock the data bus carries address bits 7:0 with the low latch active. In the second it carries the address bits above bit 7, zero-extended, with the high latch active. pad_addr is 0.
- R5: Partial mode (cfg_mux=1): there is one latch clock with address bits 7:0 on the data bus and the low latch active. pad_addr carries the address with bits 7:0 forced to 0. The high latch never activates.
- R6: Demultiplexed mode (cfg_mux=0, and also 3): pad_addr carries address bits ADDR_W-2:0, and neither latch activates.
- R7: With cfg_cs_en=1, pad_cs is active in every busy clock and the address is ADDR_W-1 bits wide; its top bit is forced to 0. With cfg_cs_en=0, pad_cs carries address bit ADDR_W-1 and the address is ADDR_W bits wide.
- R8: With cfg_style=0, pad_rd is active only in the strobe phase of a read and pad_wr only in the strobe phase of a write. With cfg_style=1, pad_rd is a direction line that is active in the setup, strobe and hold phases of a read, and pad_wr is an enable that is active in the strobe phase of either command.
- R9: cfg_pol bit 0 sets the level of pad_cs, bit 1 both latch pins, bit 2 pad_rd and bit 3 pad_wr. A bit value of 1 makes the pin active-high and 0 makes it active-low.
- R10: On a read, rd_data takes the pad_din value present in the last strobe clock, and it is valid when done is 1.
- R11: pad_doe is 1 only in latch clocks and in the setup, strobe and hold phases of a write. At those times pad_dout carries the latched address byte or the write data.
- R12: cfg_step selects the address update after the hold phase: 0 or 3 keeps the address, 1 adds one and 2 subtracts one, wrapping within the enabled width. With req_load=1 the transfer uses req_addr; otherwise it uses the address left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_load | input | 1 | Use req_addr instead of the stepped address |
| req_addr | input | ADDR_W | Address to load |
| req_wdata | input | 8 | Write byte |
| cfg_mux | input | 2 | Address mode: 0 demux, 1 partial, 2 full |
| cfg_style | input | 1 | Strobe style: 0 read/write, 1 direction/enable |
| cfg_cs_en | input | 1 | Chip select enable |
| cfg_pol | input | 4 | Per-pin active levels |
| cfg_wait_setup | input | 4 | Extra setup clocks |
| cfg_wait_strobe | input | 4 | Extra strobe clocks |
| cfg_wait_hold | input | 4 | Extra hold clocks |
| cfg_step | input | 2 | Address step after a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte |
| pad_addr | output | ADDR_W-1 | Dedicated address lines |
| pad_cs | output | 1 | Chip select, or top address bit |
| pad_latch_lo | output | 1 | Low address byte latch |
| pad_latch_hi | output | 1 | High address byte latch |
| pad_rd | output | 1 | Read strobe or direction line |
| pad_wr | output | 1 | Write strobe or enable |
| pad_dout | output | 8 | Data bus output value |
| pad_doe | output | 1 | Data bus output enable |
| pad_din | input | 8 | Data bus input value |

## Verification
The bench builds the block with the default ADDR_W of 12, which gives eleven dedicated address lines and a twelve-bit address when the chip select pin is freed. At this width a single step from 0x7FF or 0xFFF, or a decrement from 0, reaches both wrap points. The high latch phase also carries a non-empty upper nibble. Every transfer's pin trace is compared clock by clock with a trace computed from the configuration. This covers all three address modes, both strobe styles, mixed polarities and both minimum and stretched wait counts.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam int WAIT_W = 4;

    localparam logic [1:0] MX_DEMUX = 2'd0;
    localparam logic [1:0] MX_PART  = 2'd1;
    localparam logic [1:0] MX_FULL  = 2'd2;

    localparam logic [1:0] STEP_INC = 2'd1;
    localparam logic [1:0] STEP_DEC = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADRL,
        PH_ADRH,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [1:0]        mux;
        logic              style;
        logic              cs_en;
        logic [3:0]        pol;
        logic [WAIT_W-1:0] w_setup;
        logic [WAIT_W-1:0] w_strobe;
        logic [WAIT_W-1:0] w_hold;
        logic [1:0]        step;
    } cfg_t;
endpackage

// File: rtl/pbm_seq.sv
module pbm_seq
    import pbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mux,
    input  logic [WAIT_W-1:0] w_setup,
    input  logic [WAIT_W-1:0] w_strobe,
    input  logic [WAIT_W-1:0] w_hold,
    output phase_e            phase,
    output logic              strobe_last,
    output logic              xfer_end
);
    typedef struct packed {
        phase_e            ph;
        logic [WAIT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (mux == MX_FULL || mux == MX_PART) begin
                        s_d.ph = PH_ADRL;
                    end else begin
                        s_d.ph  = PH_SETUP;
                        s_d.cnt = w_setup;
                    end
                end
            end
            PH_ADRL: begin
                if (mux == MX_FULL) begin
                    s_d.ph = PH_ADRH;
                end else begin
                    s_d.ph  = PH_SETUP;
                    s_d.cnt = w_setup;
                end
            end
            PH_ADRH: begin
                s_d.ph  = PH_SETUP;
                s_d.cnt = w_setup;
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = w_strobe;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = w_hold;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase       = s_q.ph;
    assign strobe_last = (s_q.ph == PH_STROBE) && (s_q.cnt == '0);
    assign xfer_end    = (s_q.ph == PH_HOLD) && (s_q.cnt == '0);
endmodule

// File: rtl/pbm_addr.sv
module pbm_addr
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              cs_en_new,
    input  logic              step_now,
    input  logic [1:0]        step,
    input  logic              cs_en_cur,
    output logic [ADDR_W-1:0] cur_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } addr_t;

    addr_t a_d, a_q;

    function automatic logic [ADDR_W-1:0] width_mask(input logic cs_en);
        logic [ADDR_W-1:0] m;
        m = '1;
        if (cs_en) m[ADDR_W-1] = 1'b0;
        return m;
    endfunction

    always_comb begin
        a_d = a_q;
        if (accept) begin
            a_d.addr = (load ? load_val : a_q.addr) & width_mask(cs_en_new);
        end else if (step_now) begin
            if (step == STEP_INC) begin
                a_d.addr = (a_q.addr + 1'b1) & width_mask(cs_en_cur);
            end else if (step == STEP_DEC) begin
                a_d.addr = (a_q.addr - 1'b1) & width_mask(cs_en_cur);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign cur_addr = a_q.addr;
endmodule

// File: rtl/pbm_pins.sv
module pbm_pins
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic [1:0]        mux,
    input  logic              style,
    input  logic              cs_en,
    input  logic [3:0]        pol,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-2:0] pad_addr,
    output logic              pad_cs,
    output logic              pad_latch_lo,
    output logic              pad_latch_hi,
    output logic              pad_rd,
    output logic              pad_wr,
    output logic [DATA_W-1:0] pad_dout,
    output logic              pad_doe
);
    localparam int NPIN = 5;
    localparam int HI_W = ADDR_W - DATA_W;

    logic [NPIN-1:0] act;
    logic [NPIN-1:0] lvl;
    logic            data_ph;

    always_comb begin
        data_ph = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        act[0]  = (phase != PH_IDLE);
        act[1]  = (phase == PH_ADRL);
        act[2]  = (phase == PH_ADRH);
        act[3]  = style ? (data_ph && !wr) : ((phase == PH_STROBE) && !wr);
        act[4]  = style ? (phase == PH_STROBE) : ((phase == PH_STROBE) && wr);
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pol
        localparam int PSEL = (i == 0) ? 0 : ((i <= 2) ? 1 : i - 1);
        assign lvl[i] = act[i] ~^ pol[PSEL];
    end

    assign pad_cs       = cs_en ? lvl[0] : addr[ADDR_W-1];
    assign pad_latch_lo = lvl[1];
    assign pad_latch_hi = lvl[2];
    assign pad_rd       = lvl[3];
    assign pad_wr       = lvl[4];

    always_comb begin
        pad_dout = '0;
        pad_doe  = 1'b0;
        if (phase == PH_ADRL) begin
            pad_dout = addr[DATA_W-1:0];
            pad_doe  = 1'b1;
        end else if (phase == PH_ADRH) begin
            pad_dout = DATA_W'(addr[ADDR_W-1:DATA_W]);
            pad_doe  = 1'b1;
        end else if (data_ph && wr) begin
            pad_dout = wdata;
            pad_doe  = 1'b1;
        end
    end

    always_comb begin
        if (mux == MX_FULL) begin
            pad_addr = '0;
        end else if (mux == MX_PART) begin
            pad_addr = {addr[ADDR_W-2:DATA_W], {DATA_W{1'b0}}};
        end else begin
            pad_addr = addr[ADDR_W-2:0];
        end
    end

    if (HI_W < 2) begin : g_width_guard
        initial $error("ADDR_W must exceed DATA_W by at least 2");
    end
endmodule

// File: rtl/pbm_master.sv
module pbm_master
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_mux,
    input  logic              cfg_style,
    input  logic              cfg_cs_en,
    input  logic [3:0]        cfg_pol,
    input  logic [3:0]        cfg_wait_setup,
    input  logic [3:0]        cfg_wait_strobe,
    input  logic [3:0]        cfg_wait_hold,
    input  logic [1:0]        cfg_step,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-2:0] pad_addr,
    output logic              pad_cs,
    output logic              pad_latch_lo,
    output logic              pad_latch_hi,
    output logic              pad_rd,
    output logic              pad_wr,
    output logic [DATA_W-1:0] pad_dout,
    output logic              pad_doe,
    input  logic [DATA_W-1:0] pad_din
);
    typedef struct packed {
        cfg_t              cfg;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } top_t;

    top_t t_d, t_q;

    phase_e            phase;
    logic              strobe_last;
    logic              xfer_end;
    logic              accept;
    cfg_t              cfg_in;
    cfg_t              cfg_use;
    logic [ADDR_W-1:0] cur_addr;

    always_comb begin
        cfg_in.mux      = cfg_mux;
        cfg_in.style    = cfg_style;
        cfg_in.cs_en    = cfg_cs_en;
        cfg_in.pol      = cfg_pol;
        cfg_in.w_setup  = cfg_wait_setup;
        cfg_in.w_strobe = cfg_wait_strobe;
        cfg_in.w_hold   = cfg_wait_hold;
        cfg_in.step     = cfg_step;
        accept          = req_valid && (phase == PH_IDLE);
        cfg_use         = accept ? cfg_in : t_q.cfg;
    end

    always_comb begin
        t_d      = t_q;
        t_d.done = xfer_end;
        if (accept) begin
            t_d.cfg   = cfg_in;
            t_d.wr    = req_write;
            t_d.wdata = req_wdata;
        end
        if (strobe_last && !t_q.wr) begin
            t_d.rdata = pad_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q           <= '0;
            t_q.cfg.cs_en <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    pbm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .mux         (cfg_use.mux),
        .w_setup     (cfg_use.w_setup),
        .w_strobe    (cfg_use.w_strobe),
        .w_hold      (cfg_use.w_hold),
        .phase       (phase),
        .strobe_last (strobe_last),
        .xfer_end    (xfer_end)
    );

    pbm_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .load      (req_load),
        .load_val  (req_addr),
        .cs_en_new (cfg_in.cs_en),
        .step_now  (xfer_end),
        .step      (t_q.cfg.step),
        .cs_en_cur (t_q.cfg.cs_en),
        .cur_addr  (cur_addr)
    );

    pbm_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase        (phase),
        .mux          (t_q.cfg.mux),
        .style        (t_q.cfg.style),
        .cs_en        (t_q.cfg.cs_en),
        .pol          (t_q.cfg.pol),
        .wr           (t_q.wr),
        .wdata        (t_q.wdata),
        .addr         (cur_addr),
        .pad_addr     (pad_addr),
        .pad_cs       (pad_cs),
        .pad_latch_lo (pad_latch_lo),
        .pad_latch_hi (pad_latch_hi),
        .pad_rd       (pad_rd),
        .pad_wr       (pad_wr),
        .pad_dout     (pad_dout),
        .pad_doe      (pad_doe)
    );

    assign busy    = (phase != PH_IDLE);
    assign done    = t_q.done;
    assign rd_data = t_q.rdata;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              pad_doe,
    input logic [ADDR_W-1:0] cur_addr
);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r3_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy);

    a_r11_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pad_doe);

    a_r12_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));
endmodule

bind pbm_master pbm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .pad_doe  (pad_doe),
    .cur_addr (cur_addr)
);

// File: tb/tb_pbm_master.sv
module tb_pbm_master;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_load = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic [1:0]    c_mux = 2'd0;
    logic          c_style = 1'b0, c_cs_en = 1'b1;
    logic [3:0]    c_pol = 4'h0, c_ws = 4'd0, c_wt = 4'd0, c_wh = 4'd0;
    logic [1:0]    c_step = 2'd0;
    logic          busy, done;
    logic [7:0]    rd_data, pad_dout, pad_din = 8'h00;
    logic [AW-2:0] pad_addr;
    logic          pad_cs, pad_ll, pad_lh, pad_rd, pad_wr, pad_doe;

    int n_chk = 0, n_fail = 0, n = 0;
    logic          t_cs[64], t_rd[64], t_wr[64], t_ll[64], t_lh[64], t_oe[64], t_busy[64];
    logic [7:0]    t_do[64];
    logic [AW-2:0] t_ad[64];

    always #5 clk = ~clk;

    pbm_master #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_load(req_load), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_mux(c_mux), .cfg_style(c_style), .cfg_cs_en(c_cs_en), .cfg_pol(c_pol),
        .cfg_wait_setup(c_ws), .cfg_wait_strobe(c_wt), .cfg_wait_hold(c_wh),
        .cfg_step(c_step), .busy(busy), .done(done), .rd_data(rd_data),
        .pad_addr(pad_addr), .pad_cs(pad_cs), .pad_latch_lo(pad_ll),
        .pad_latch_hi(pad_lh), .pad_rd(pad_rd), .pad_wr(pad_wr),
        .pad_dout(pad_dout), .pad_doe(pad_doe), .pad_din(pad_din)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Issue one request and record the pins in every clock until done.
    task automatic run(input logic wr, input logic ld, input logic [AW-1:0] a,
                       input logic [7:0] wd, input bit poke);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_load = ld; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 64) begin
            t_cs[n] = pad_cs; t_rd[n] = pad_rd; t_wr[n] = pad_wr;
            t_ll[n] = pad_ll; t_lh[n] = pad_lh; t_oe[n] = pad_doe;
            t_do[n] = pad_dout; t_ad[n] = pad_addr; t_busy[n] = busy;
            pad_din = 8'h40 + 8'(n);
            if (poke && n == 1) begin
                req_valid = 1'b1; req_load = 1'b1; req_addr = 12'h123; req_write = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Compare the recorded trace with one computed from the configuration.
    task automatic check_trace(input logic wr, input logic [AW-1:0] a, input logic [7:0] wd);
        int na, total, e_cs, e_str, e_lat, e_bus, e_adr, e_busy;
        logic [AW-2:0] exp_ad;
        string mtag;
        na = (c_mux == 2'd2) ? 2 : (c_mux == 2'd1) ? 1 : 0;
        mtag = (c_mux == 2'd2) ? "R4" : (c_mux == 2'd1) ? "R5" : "R6";
        total = na + int'(c_ws) + int'(c_wt) + int'(c_wh) + 3;
        exp_ad = (c_mux == 2'd2) ? '0 :
                 (c_mux == 2'd1) ? {a[AW-2:8], 8'h00} : a[AW-2:0];
        e_cs = 0; e_str = 0; e_lat = 0; e_bus = 0; e_adr = 0; e_busy = 0;
        check(n == total, "R3 transfer length", n, total);
        for (int i = 0; i < n && i < 64; i++) begin
            bit ph_l, ph_h, ph_d, ph_s, a_rd, a_wr, e_oe;
            logic [7:0] e_do;
            ph_l = (na >= 1) && (i == 0);
            ph_h = (na == 2) && (i == 1);
            ph_d = (i >= na);
            ph_s = (i >= na + int'(c_ws) + 1) && (i < na + int'(c_ws) + int'(c_wt) + 2);
            a_rd = c_style ? (ph_d && !wr) : (ph_s && !wr);
            a_wr = c_style ? ph_s : (ph_s && wr);
            if (c_cs_en) begin
                if (t_cs[i] !== c_pol[0]) e_cs++;
            end else if (t_cs[i] !== a[AW-1]) e_cs++;
            if (t_rd[i] !== (c_pol[2] ? a_rd : !a_rd)) e_str++;
            if (t_wr[i] !== (c_pol[3] ? a_wr : !a_wr)) e_str++;
            if (t_ll[i] !== (c_pol[1] ? ph_l : !ph_l)) e_lat++;
            if (t_lh[i] !== (c_pol[1] ? ph_h : !ph_h)) e_lat++;
            e_oe = ph_l || ph_h || (ph_d && wr);
            e_do = ph_l ? a[7:0] : ph_h ? {4'h0, a[11:8]} : wd;
            if (t_oe[i] !== e_oe) e_bus++;
            else if (e_oe && t_do[i] !== e_do) e_bus++;
            if (t_ad[i] !== exp_ad) e_adr++;
            if (t_busy[i] !== 1'b1) e_busy++;
        end
        check(e_busy == 0, "R2 busy throughout", e_busy, 0);
        check(e_cs == 0, "R7/R9 chip select pin", e_cs, 0);
        check(e_str == 0, "R8/R9 strobe pins", e_str, 0);
        check(e_lat == 0, {mtag, " latch pins"}, e_lat, 0);
        check(e_bus == 0, "R11 data bus drive", e_bus, 0);
        check(e_adr == 0, {mtag, " address lines"}, e_adr, 0);
        check(done === 1'b1 && busy === 1'b0, "R2 done with busy low", {busy, done}, 1);
        if (!wr) begin
            logic [7:0] e_rd;
            e_rd = 8'h40 + 8'(na + int'(c_ws) + int'(c_wt) + 1);
            check(rd_data === e_rd, "R10 read capture", rd_data, e_rd);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic st, input logic cs,
                           input logic [3:0] p, input logic [3:0] ws, input logic [3:0] wt,
                           input logic [3:0] wh, input logic [1:0] sp);
        c_mux = m; c_style = st; c_cs_en = cs; c_pol = p;
        c_ws = ws; c_wt = wt; c_wh = wh; c_step = sp;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && pad_doe === 1'b0, "R1 idle flags",
              {busy, done, pad_doe}, 0);
        check({pad_cs, pad_rd, pad_wr, pad_ll, pad_lh} === 5'b11111, "R1 inactive pins",
              {pad_cs, pad_rd, pad_wr, pad_ll, pad_lh}, 5'h1f);
        check(pad_addr === '0, "R1 address lines", pad_addr, 0);
    endtask

    task automatic t_demux();
        set_cfg(2'd0, 1'b0, 1'b1, 4'h0, 4'd1, 4'd2, 4'd1, 2'd0);
        run(1'b1, 1'b1, 12'h5A3, 8'hC7, 1'b0);
        check_trace(1'b1, 12'h5A3, 8'hC7);     // R6 write
        run(1'b0, 1'b0, 12'h000, 8'h00, 1'b0);
        check_trace(1'b0, 12'h5A3, 8'h00);     // R10 read, address kept (R12)
        set_cfg(2'd0, 1'b0, 1'b1, 4'h0, 4'd0, 4'd0, 4'd0, 2'd0);
        run(1'b0, 1'b1, 12'h011, 8'h00, 1'b0);
        check_trace(1'b0, 12'h011, 8'h00);     // R3 minimum length
    endtask

    task automatic t_full();
        set_cfg(2'd2, 1'b0, 1'b0, 4'hF, 4'd2, 4'd1, 4'd0, 2'd0);
        run(1'b1, 1'b1, 12'hB6E, 8'h3D, 1'b0);
        check_trace(1'b1, 12'hB6E, 8'h3D);     // R4 with active-high pins (R9)
        set_cfg(2'd2, 1'b1, 1'b1, 4'b0110, 4'd0, 4'd3, 4'd2, 2'd0);
        run(1'b0, 1'b1, 12'hFA5, 8'h00, 1'b0);
        check_trace(1'b0, 12'h7A5, 8'h00);     // R4 read, top bit masked (R7)
    endtask

    task automatic t_partial();
        set_cfg(2'd1, 1'b1, 1'b1, 4'b1001, 4'd1, 4'd1, 4'd1, 2'd0);
        run(1'b0, 1'b1, 12'h3C4, 8'h00, 1'b0);
        check_trace(1'b0, 12'h3C4, 8'h00);     // R5 with direction/enable (R8)
        run(1'b1, 1'b0, 12'h000, 8'h9E, 1'b0);
        check_trace(1'b1, 12'h3C4, 8'h9E);     // R5 write, enable style
    endtask

    task automatic t_wrap_nocs();
        set_cfg(2'd0, 1'b0, 1'b0, 4'h0, 4'd0, 4'd1, 4'd0, 2'd1);
        run(1'b1, 1'b1, 12'hFFF, 8'h11, 1'b0);
        check_trace(1'b1, 12'hFFF, 8'h11);     // R7 pin carries top bit
        run(1'b1, 1'b0, 12'h000, 8'h22, 1'b0);
        check(t_ad[0] === '0 && t_cs[0] === 1'b0, "R12 wrap at 12 bits",
              {t_cs[0], t_ad[0]}, 0);
        check_trace(1'b1, 12'h000, 8'h22);
    endtask

    task automatic t_wrap_cs();
        set_cfg(2'd0, 1'b0, 1'b1, 4'h0, 4'd0, 4'd0, 4'd0, 2'd1);
        run(1'b1, 1'b1, 12'hFFF, 8'h01, 1'b0);
        check(t_ad[0] === 11'h7FF, "R7 address masked to 11 bits", t_ad[0], 11'h7FF);
        c_step = 2'd2;
        run(1'b1, 1'b0, 12'h000, 8'h02, 1'b0);
        check(t_ad[0] === 11'h000, "R12 increment wraps at 11 bits", t_ad[0], 0);
        c_step = 2'd0;
        run(1'b0, 1'b0, 12'h000, 8'h00, 1'b0);
        check(t_ad[0] === 11'h7FF, "R12 decrement wraps", t_ad[0], 11'h7FF);
        run(1'b0, 1'b0, 12'h000, 8'h00, 1'b0);
        check(t_ad[0] === 11'h7FF, "R12 keep mode", t_ad[0], 11'h7FF);
    endtask

    task automatic t_ignore();
        set_cfg(2'd0, 1'b0, 1'b1, 4'h0, 4'd1, 4'd1, 4'd1, 2'd1);
        run(1'b0, 1'b1, 12'h020, 8'h00, 1'b1);
        check_trace(1'b0, 12'h020, 8'h00);     // R2 poke during busy
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R2 request while busy ignored",
              {busy, done}, 0);
        run(1'b0, 1'b0, 12'h000, 8'h00, 1'b0);
        check(t_ad[0] === 11'h021, "R2 ignored request left address", t_ad[0], 11'h021);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_demux();
        t_full();
        t_partial();
        t_wrap_nocs();
        t_wrap_cs();
        t_ignore();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule